// File: doc/BRIEF.md
# Save-RAM Window With Dirty Tracking

This block sits on the console side of a cartridge and serves a battery-style save memory. The save window starts at byte address 0x200000 of the low cartridge region. It holds one byte for each odd console byte address, and those bytes are kept in an external byte-wide backing RAM. Accesses in the window are passed straight through to that RAM. A write of the odd byte at console address 0xA130F1 switches the window on or off. This lets an image larger than 2 MiB get its ROM back in the overlapping range. While the window is off, the block does not claim the access, so the ROM decoder answers instead.

The block also records the lowest and highest odd byte address written since the last clear, and it raises a dirty flag on the first such write. Firmware can then copy only the touched range to storage, for example when reset is pressed. A one-cycle clear strobe on the status side restarts the tracking. A console write in the same cycle as the clear is recorded after the clear.

The console bus is single-cycle. A valid strobe, a write flag, two byte-lane strobes (upper and lower, where the lower lane is the odd byte) and a 23-bit word address are sampled in one cycle. The backing RAM has an asynchronous read.

Top module: `save_ram_window`

## Requirements
- R1: After reset the window is enabled (st_enabled=1), st_lo is 0xFFFFFF, st_hi is 0x000000 and st_dirty is 0.
- R2: A valid write with con_lds=1 to word address W, where the odd byte address {W,1} lies in [0x200000, 0x200000+2*RAM_DEPTH) and the window is enabled, asserts ram_we in the same cycle. It drives ram_addr = ({W,1}-0x200000)>>1 and ram_wdata = con_wdata.
- R3: A write inside the enabled window with only con_uds set (even byte) is claimed but never asserts ram_we and does not change st_lo, st_hi or st_dirty.
- R4: A valid read (con_we=0, at least one lane strobe) inside the enabled window asserts con_claim and ram_we=0, and returns con_rdata = {0xFF, ram_rdata}. In every other cycle con_rdata is 0.
- R5: A valid write with con_lds=1 to word address 0x509878 (byte 0xA130F1) loads con_wdata bit 0 into st_enabled on the next clock (1 = save RAM, 0 = ROM). It never asserts ram_we.
- R6: While st_enabled is 0, accesses to the window are not claimed, never assert ram_we and leave the tracked range unchanged.
- R7: Accesses whose odd byte address is below 0x200000 or at or above 0x200000+2*RAM_DEPTH are not claimed, never assert ram_we and are not tracked.
- R8: On the clock after each write that asserts ram_we, st_lo becomes the smaller and st_hi the larger of their old values and the written odd byte address {W,1}, and st_dirty becomes 1. While st_dirty is 1, st_lo <= st_hi.
- R9: A st_clear pulse with no recorded write returns st_lo, st_hi and st_dirty to their reset values on the next clock.
- R10: When st_clear and a recorded write happen in the same cycle, the next clock gives st_lo = st_hi = the written address and st_dirty = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| con_valid | input | 1 | Console access present this cycle |
| con_we | input | 1 | 1 = write, 0 = read |
| con_uds | input | 1 | Upper (even) byte lane strobe |
| con_lds | input | 1 | Lower (odd) byte lane strobe |
| con_waddr | input | 23 | Console word address (byte address bits 23..1) |
| con_wdata | input | 8 | Odd-lane write data |
| con_claim | output | 1 | Block answers this access (save RAM selected over ROM) |
| con_rdata | output | 16 | Read data, even lane 0xFF, odd lane from backing RAM |
| ram_addr | output | RAM_AW | Backing RAM byte index |
| ram_we | output | 1 | Backing RAM write enable |
| ram_wdata | output | 8 | Backing RAM write data |
| ram_rdata | input | 8 | Backing RAM asynchronous read data |
| st_clear | input | 1 | Clear the tracked range and dirty flag |
| st_enabled | output | 1 | Save window enabled |
| st_lo | output | 24 | Lowest odd byte address written |
| st_hi | output | 24 | Highest odd byte address written |
| st_dirty | output | 1 | At least one write recorded since clear |

## Verification
Directed accesses hit the first and last backed byte and the odd bytes just outside each edge of the window. These tell an off-by-one in the range compare apart from a correct decode. Even-only writes, control writes with both values of bit 0, and clears with and without a coincident write each isolate one path of the tracker or gate. A long seeded random mix then interleaves reads, writes, lane patterns, enable toggles and clears. The bench predicts the claim, RAM strobe, read data and running minimum and maximum every cycle, so an ordering error between clear and update, or a tracking leak while disabled, shows up as a mismatch.

// File: rtl/savewin_pkg.sv
package savewin_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_SAVE_RD,
    ACC_SAVE_WR,
    ACC_SAVE_DROP,
    ACC_CTRL_WR
  } acc_kind_e;

  localparam logic [23:0] DEF_WIN_BASE  = 24'h200000;
  localparam logic [23:0] DEF_CTRL_ADDR = 24'hA130F1;
endpackage

// File: rtl/savewin_decode.sv
module savewin_decode
  import savewin_pkg::*;
#(
  parameter int unsigned   ADDR_W    = 23,
  parameter int unsigned   RAM_DEPTH = 4096,
  parameter int unsigned   RAM_AW    = 12,
  parameter logic [ADDR_W:0] WIN_BASE  = DEF_WIN_BASE,
  parameter logic [ADDR_W:0] CTRL_ADDR = DEF_CTRL_ADDR
) (
  input  logic              valid,
  input  logic              we,
  input  logic              uds,
  input  logic              lds,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              win_en,
  output acc_kind_e         kind,
  output logic [RAM_AW-1:0] ram_idx
);
  localparam logic [ADDR_W-1:0] WB_W   = WIN_BASE[ADDR_W:1];
  localparam logic [ADDR_W:0]   WEND_W = {1'b0, WB_W} + (ADDR_W+1)'(RAM_DEPTH);
  localparam logic [ADDR_W-1:0] CTRL_W = CTRL_ADDR[ADDR_W:1];

  logic in_win;
  logic any_lane;

  assign in_win   = ({1'b0, waddr} >= {1'b0, WB_W}) && ({1'b0, waddr} < WEND_W);
  assign any_lane = uds | lds;
  assign ram_idx  = RAM_AW'(waddr - WB_W);

  always_comb begin
    kind = ACC_NONE;
    if (valid) begin
      if (we && lds && (waddr == CTRL_W)) begin
        kind = ACC_CTRL_WR;
      end else if (in_win && win_en && any_lane) begin
        if (!we)       kind = ACC_SAVE_RD;
        else if (lds)  kind = ACC_SAVE_WR;
        else           kind = ACC_SAVE_DROP;
      end
    end
  end
endmodule

// File: rtl/savewin_ctrl.sv
module savewin_ctrl
  import savewin_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  acc_kind_e kind,
  input  logic      sel_bit,
  output logic      win_en
);
  logic en_q;
  logic en_d;
  logic en_ce;

  assign en_ce = (kind == ACC_CTRL_WR);

  always_comb begin
    en_d = en_q;
    if (en_ce) en_d = sel_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else if (en_ce) en_q <= en_d;
  end

  assign win_en = en_q;

  assert_ctrl_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_CTRL_WR) |=> (win_en == $past(sel_bit)));
endmodule

// File: rtl/savewin_track.sv
module savewin_track #(
  parameter int unsigned TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [TW-1:0] upd_addr,
  input  logic          clr,
  output logic [TW-1:0] lo,
  output logic [TW-1:0] hi,
  output logic          dirty
);
  logic [TW-1:0] lo_q, hi_q, lo_d, hi_d;
  logic [TW-1:0] lo_base, hi_base;
  logic          dirty_q, dirty_d, dirty_base;
  logic          ce;

  assign ce = upd | clr;

  always_comb begin
    lo_base    = clr ? '1 : lo_q;
    hi_base    = clr ? '0 : hi_q;
    dirty_base = clr ? 1'b0 : dirty_q;
    lo_d    = lo_base;
    hi_d    = hi_base;
    dirty_d = dirty_base;
    if (upd) begin
      if (upd_addr < lo_base) lo_d = upd_addr;
      if (upd_addr > hi_base) hi_d = upd_addr;
      dirty_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '1;
      hi_q    <= '0;
      dirty_q <= 1'b0;
    end else if (ce) begin
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      dirty_q <= dirty_d;
    end
  end

  assign lo    = lo_q;
  assign hi    = hi_q;
  assign dirty = dirty_q;

  assert_dirty_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> dirty);
  assert_range_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dirty |-> (lo <= hi));
  assert_clear_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !upd) |=> (!dirty && (lo == '1) && (hi == '0)));
  assert_clear_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && upd) |=> (dirty && (lo == $past(upd_addr)) && (hi == $past(upd_addr))));
endmodule

// File: rtl/save_ram_window.sv
module save_ram_window
  import savewin_pkg::*;
#(
  parameter int unsigned ADDR_W    = 23,
  parameter int unsigned RAM_DEPTH = 4096,
  parameter logic [ADDR_W:0] WIN_BASE  = DEF_WIN_BASE,
  parameter logic [ADDR_W:0] CTRL_ADDR = DEF_CTRL_ADDR,
  localparam int unsigned RAM_AW = $clog2(RAM_DEPTH),
  localparam int unsigned TW     = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              con_valid,
  input  logic              con_we,
  input  logic              con_uds,
  input  logic              con_lds,
  input  logic [ADDR_W-1:0] con_waddr,
  input  logic [7:0]        con_wdata,
  output logic              con_claim,
  output logic [15:0]       con_rdata,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_we,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  input  logic              st_clear,
  output logic              st_enabled,
  output logic [TW-1:0]     st_lo,
  output logic [TW-1:0]     st_hi,
  output logic              st_dirty
);
  acc_kind_e         kind;
  logic              win_en;
  logic [RAM_AW-1:0] idx;
  logic              save_wr;

  savewin_decode #(
    .ADDR_W(ADDR_W), .RAM_DEPTH(RAM_DEPTH), .RAM_AW(RAM_AW),
    .WIN_BASE(WIN_BASE), .CTRL_ADDR(CTRL_ADDR)
  ) u_decode (
    .valid(con_valid), .we(con_we), .uds(con_uds), .lds(con_lds),
    .waddr(con_waddr), .win_en(win_en), .kind(kind), .ram_idx(idx)
  );

  savewin_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .kind(kind), .sel_bit(con_wdata[0]), .win_en(win_en)
  );

  assign save_wr = (kind == ACC_SAVE_WR);

  savewin_track #(.TW(TW)) u_track (
    .clk(clk), .rst_n(rst_n), .upd(save_wr), .upd_addr({con_waddr, 1'b1}),
    .clr(st_clear), .lo(st_lo), .hi(st_hi), .dirty(st_dirty)
  );

  always_comb begin
    con_claim = (kind == ACC_SAVE_RD) || (kind == ACC_SAVE_WR) || (kind == ACC_SAVE_DROP);
    con_rdata = (kind == ACC_SAVE_RD) ? {8'hFF, ram_rdata} : 16'h0000;
  end

  assign ram_addr   = idx;
  assign ram_we     = save_wr;
  assign ram_wdata  = con_wdata;
  assign st_enabled = win_en;

  assert_disabled_no_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !st_enabled |-> !ram_we);
  assert_read_no_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (con_valid && !con_we) |-> !ram_we);
  assert_we_odd_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (con_lds && con_we && con_claim));
endmodule

// File: tb/test_save_ram_window.sv
`timescale 1ns/1ps
module test_save_ram_window;
  localparam int unsigned DEPTH = 4096;
  localparam int unsigned AW    = 12;
  localparam logic [22:0] WB    = 23'h100000;
  localparam logic [22:0] CW    = 23'h509878;

  logic clk = 1'b0;
  logic rst_n;
  logic valid, we, uds, lds, clr;
  logic [22:0] waddr;
  logic [7:0]  wdata;
  logic        claim, ram_we, en, dirty;
  logic [15:0] rdata;
  logic [AW-1:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic [23:0] lo, hi;

  logic [7:0]  mem [DEPTH];
  logic        m_en, m_dirty;
  logic [23:0] m_lo, m_hi;
  string       st_tag;
  int          checks = 0;
  int          fails  = 0;

  always #2.5 clk = ~clk;

  assign ram_rdata = mem[ram_addr];

  save_ram_window i_save_ram_window (
    .clk(clk), .rst_n(rst_n), .con_valid(valid), .con_we(we), .con_uds(uds),
    .con_lds(lds), .con_waddr(waddr), .con_wdata(wdata), .con_claim(claim),
    .con_rdata(rdata), .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .st_clear(clr), .st_enabled(en), .st_lo(lo),
    .st_hi(hi), .st_dirty(dirty)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [22:0] a);
    logic [23:0] ba;
    ba = {a, 1'b1};
    return (ba >= 24'h200000) && (ba < 24'h200000 + 24'(2*DEPTH));
  endfunction

  task automatic check_status();
    chk(lo == m_lo, st_tag, "st_lo", 32'(lo), 32'(m_lo));
    chk(hi == m_hi, st_tag, "st_hi", 32'(hi), 32'(m_hi));
    chk(dirty == m_dirty, st_tag, "st_dirty", 32'(dirty), 32'(m_dirty));
    chk(en == m_en, "R5", "st_enabled", 32'(en), 32'(m_en));
  endtask

  task automatic step(input bit v, input bit w, input bit u, input bit l,
                      input logic [22:0] a, input logic [7:0] d, input bit c);
    bit iw, e_claim, e_we, e_rd, ctl;
    logic [AW-1:0] e_idx;
    string tag;
    valid = v; we = w; uds = u; lds = l; waddr = a; wdata = d; clr = c;
    #1;
    iw      = in_win(a);
    e_claim = v && iw && m_en && (u || l);
    e_we    = v && w && l && iw && m_en;
    e_rd    = v && !w && (u || l) && iw && m_en;
    ctl     = v && w && l && (a == CW);
    e_idx   = AW'(a - WB);
    tag = !iw ? "R7" : (!m_en ? "R6" : ((w && !l) ? "R3" : (w ? "R2" : "R4")));
    check_status();
    chk(claim == e_claim, tag, "con_claim", 32'(claim), 32'(e_claim));
    chk(ram_we == e_we, ctl ? "R5" : tag, "ram_we", 32'(ram_we), 32'(e_we));
    if (e_we) begin
      chk(ram_addr == e_idx, "R2", "ram_addr", 32'(ram_addr), 32'(e_idx));
      chk(ram_wdata == d, "R2", "ram_wdata", 32'(ram_wdata), 32'(d));
    end
    if (e_rd) chk(rdata == {8'hFF, mem[e_idx]}, "R4", "con_rdata", 32'(rdata), {16'h0, 8'hFF, mem[e_idx]});
    else      chk(rdata == 16'h0, "R4", "con_rdata idle", 32'(rdata), 32'h0);
    @(posedge clk);
    if (c) begin m_lo = '1; m_hi = '0; m_dirty = 1'b0; end
    if (e_we) begin
      mem[e_idx] = d;
      if ({a, 1'b1} < m_lo) m_lo = {a, 1'b1};
      if ({a, 1'b1} > m_hi) m_hi = {a, 1'b1};
      m_dirty = 1'b1;
    end
    if (ctl) m_en = d[0];
    st_tag = (c && e_we) ? "R10" : (c ? "R9" : "R8");
    @(negedge clk);
  endtask

  function automatic logic [22:0] pick_addr();
    int unsigned r;
    r = $urandom % 10;
    case (r)
      0: return WB;
      1: return WB + 23'(DEPTH - 1);
      2: return WB - 23'd1;
      3: return WB + 23'(DEPTH);
      4: return CW;
      5: return 23'($urandom);
      default: return WB + 23'($urandom % DEPTH);
    endcase
  endfunction

  initial begin
    int unsigned wd;
    wd = 0;
    while (wd < 200000) begin @(posedge clk); wd++; end
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
    m_en = 1'b1; m_lo = '1; m_hi = '0; m_dirty = 1'b0; st_tag = "R1";
    rst_n = 1'b0; valid = 0; we = 0; uds = 0; lds = 0; waddr = '0; wdata = '0; clr = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check_status();
    rst_n = 1'b1;
    @(negedge clk);
    st_tag = "R1";
    // R2/R8: first and last backed byte
    step(1, 1, 0, 1, WB, 8'h5A, 0);
    step(1, 1, 1, 1, WB + 23'(DEPTH - 1), 8'hC3, 0);
    // R4: read back both ends
    step(1, 0, 1, 1, WB, 8'h00, 0);
    step(1, 0, 0, 1, WB + 23'(DEPTH - 1), 8'h00, 0);
    // R3: even-only write
    step(1, 1, 1, 0, WB + 23'd7, 8'hEE, 0);
    // R7: just outside both edges
    step(1, 1, 0, 1, WB - 23'd1, 8'h11, 0);
    step(1, 1, 0, 1, WB + 23'(DEPTH), 8'h22, 0);
    // R5/R6: disable, try access, re-enable
    step(1, 1, 0, 1, CW, 8'hFE, 0);
    step(1, 1, 0, 1, WB + 23'd5, 8'h33, 0);
    step(1, 0, 0, 1, WB + 23'd5, 8'h00, 0);
    step(1, 1, 0, 1, CW, 8'h01, 0);
    // R9: clear alone, R10: clear with write
    step(0, 0, 0, 0, WB, 8'h00, 1);
    step(1, 1, 0, 1, WB + 23'd100, 8'h44, 1);
    step(0, 0, 0, 0, WB, 8'h00, 0);
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [22:0] a;
      logic [7:0]  d;
      a = pick_addr();
      d = 8'($urandom);
      if (a == CW) d[0] = (($urandom % 4) != 0);
      step(($urandom % 8) != 0, $urandom % 2, $urandom % 2, ($urandom % 4) != 0,
           a, d, ($urandom % 16) == 0);
    end
    step(0, 0, 0, 0, WB, 8'h00, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule